// File: doc/BRIEF.md
# Asynchronous static RAM sequencer

This block sits between a synchronous host and an asynchronous 128K x 8 static RAM with active-low select, output-enable and write-enable pins. The host offers one word request at a time on a valid/ready handshake. The block turns each request into a pin sequence whose phase lengths are whole clock cycles. These lengths are computed at elaboration from the clock period and the RAM speed grade. A read returns its byte on a one-cycle result strobe.

The shared data bus is split at the block edge into an output byte, an output enable and an input byte, so the pad ring can build the tri-state pin. A parameter chooses how a write ends. In one variant the write-enable rises while the select stays low. In the other the select rises while the write-enable stays low. Host drive starts only after the RAM's write-to-high-Z window has passed. After every read, a turnaround phase covers the RAM's output-disable window before the next request is accepted.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and just after it, the select, output-enable and write-enable pins are high (1), the bus output enable is 0, the result strobe is 0 and `req_ready` is 1.
- R2: Whenever no request is in progress (`req_ready` = 1), the select, output-enable and write-enable pins are all high, so the RAM stays in standby.
- R3: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` is 0 from the next cycle until the last phase of that request has finished.
- R4: Pin decode follows the RAM mode table. Output-enable low only occurs with select low and write-enable high. Write-enable low always comes with output-enable high.
- R5: A read returns the byte last written to that address (0 if never written) on `rd_data`, with a single-cycle `rd_valid` pulse. The byte is sampled no earlier than the address access time after the address was applied, and no earlier than the output-enable access time after output-enable fell.
- R6: For each write, the strobe is active for at least the write pulse width. The address is stable for at least the address-to-end-of-write time, and the data is driven and stable for at least the data setup time before the strobe ends. Address and data do not change while the strobe is active.
- R7: With `WR_BY_CS` = 0 a write ends by write-enable rising while select is low. With `WR_BY_CS` = 1 it ends by select rising while write-enable is low.
- R8: The block drives the bus only while both select and write-enable are low. It starts driving no earlier than the write-to-high-Z time after write-enable fell, and never while the RAM drives or within the output-disable time after output-enable or select rose. It releases the bus on the same edge that ends the strobe.
- R9: Successive address changes are at least one full write/read cycle time apart, and the address is held for at least one cycle after a write strobe ends.
- R10: During a read the address stays stable while select is low, and output-enable stays low for at least the read cycle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse with read byte |
| rd_data | output | 8 | Read byte |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_addr | output | 17 | RAM address |
| mem_dq_o | output | 8 | Byte driven toward the RAM |
| mem_dq_oe | output | 1 | Enables the pad driver for `mem_dq_o` |
| mem_dq_i | input | 8 | Byte seen on the RAM data pins |

## Verification
The bench builds two copies at a 4 ns clock and the 20 ns speed grade, one with `WR_BY_CS` = 0 and one with `WR_BY_CS` = 1, so both ways of ending a write are covered. At 4 ns, rounding up turns 20 ns, 15 ns, 10 ns and 8 ns limits into 5, 4, 3 and 2 cycles. Any phase that is one cycle short therefore breaks a nanosecond check in the RAM model. The models time every pin edge in nanoseconds and check access, pulse, setup, high-Z and contention limits. They also return the stored bytes, so wrong decode or wrong capture timing shows up as data mismatches.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RD_TURN, ST_W_PRE, ST_W_HIZ, ST_W_DAT, ST_W_REC
  } st_e;

  // selectors into the per-grade limit row
  localparam int L_AA  = 0;
  localparam int L_OE  = 1;
  localparam int L_OHZ = 2;
  localparam int L_CHZ = 3;
  localparam int L_WP  = 4;
  localparam int L_AW  = 5;
  localparam int L_DW  = 6;
  localparam int L_WR  = 7;
  localparam int L_WHZ = 8;

  // limit in ns for a speed grade; unknown grades fall back to the slowest
  function automatic int lim_ns(input int grade, input int sel);
    int row [9];
    case (grade)
      15:      row = '{15,  8,  6,  6, 12, 12,  7, 0,  8};
      17:      row = '{17,  8,  6,  6, 13, 13,  7, 0,  8};
      20:      row = '{20,  8,  8,  8, 15, 15, 10, 0, 10};
      25:      row = '{25, 12, 10, 10, 20, 20, 15, 0, 10};
      35:      row = '{35, 20, 15, 15, 30, 25, 20, 0, 13};
      45:      row = '{45, 20, 15, 15, 30, 35, 20, 5, 15};
      default: row = '{55, 25, 20, 20, 35, 45, 25, 5, 20};
    endcase
    return row[sel];
  endfunction

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int N_RD     = 5,
  parameter int N_RTURN  = 2,
  parameter int N_PRE    = 1,
  parameter int N_HIZ    = 3,
  parameter int N_DAT    = 3,
  parameter int N_REC    = 1,
  parameter bit WR_BY_CS = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_we,
  output logic accept,
  output st_e  state_q,
  output st_e  state_d
);
  localparam int MAXL = imax(imax(imax(N_RD, N_RTURN), imax(N_PRE, N_HIZ)), imax(N_DAT, N_REC));
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  function automatic logic [CW-1:0] len_m1(input st_e s);
    case (s)
      ST_RD:      return CW'(N_RD - 1);
      ST_RD_TURN: return CW'(N_RTURN - 1);
      ST_W_PRE:   return CW'(N_PRE - 1);
      ST_W_HIZ:   return CW'(N_HIZ - 1);
      ST_W_DAT:   return CW'(N_DAT - 1);
      ST_W_REC:   return CW'(N_REC - 1);
      default:    return '0;
    endcase
  endfunction

  assign last   = (cnt_q == '0);
  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (req_valid) state_d = !req_we ? ST_RD : (WR_BY_CS ? ST_W_PRE : ST_W_HIZ);
      ST_RD:      if (last) state_d = ST_RD_TURN;
      ST_RD_TURN: if (last) state_d = ST_IDLE;
      ST_W_PRE:   if (last) state_d = ST_W_HIZ;
      ST_W_HIZ:   if (last) state_d = ST_W_DAT;
      ST_W_DAT:   if (last) state_d = ST_W_REC;
      ST_W_REC:   if (last) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (state_d != state_q) cnt_d = len_m1(state_d);
    else if (!last)         cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_ctl_pins.sv
`timescale 1ns/1ps
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter bit WR_BY_CS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_e               state_q,
  input  st_e               state_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic cs_n_d, oe_n_d, we_n_d, dq_oe_d, capture;

  // pins are registered from the next state so strobes change on clean edges
  always_comb begin
    cs_n_d  = 1'b1;
    oe_n_d  = 1'b1;
    we_n_d  = 1'b1;
    dq_oe_d = 1'b0;
    case (state_d)
      ST_RD:    begin cs_n_d = 1'b0; oe_n_d = 1'b0; end
      ST_W_PRE: we_n_d = 1'b0;
      ST_W_HIZ: begin cs_n_d = 1'b0; we_n_d = 1'b0; end
      ST_W_DAT: begin cs_n_d = 1'b0; we_n_d = 1'b0; dq_oe_d = 1'b1; end
      ST_W_REC: begin cs_n_d = WR_BY_CS; we_n_d = !WR_BY_CS; end
      default:  ;
    endcase
  end

  assign capture = (state_q == ST_RD) && (state_d != ST_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n     <= 1'b1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      dq_oe    <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      cs_n     <= cs_n_d;
      oe_n     <= oe_n_d;
      we_n     <= we_n_d;
      dq_oe    <= dq_oe_d;
      rd_valid <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      dq_o <= '0;
    end else if (accept) begin
      addr <= req_addr;
      dq_o <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (capture) rd_data <= mem_dq_i;
  end

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS  = 4,
  parameter int SPEED_GRADE_NS = 20,
  parameter bit WR_BY_CS       = 1'b0,
  parameter int ADDR_W         = 17,
  parameter int DATA_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int G   = SPEED_GRADE_NS;
  localparam int CK  = CLK_PERIOD_NS;
  localparam int C_RC  = ns2cyc(G, CK);
  localparam int C_AA  = ns2cyc(lim_ns(G, L_AA), CK);
  localparam int C_OE  = ns2cyc(lim_ns(G, L_OE), CK);
  localparam int C_HZ  = imax(ns2cyc(lim_ns(G, L_OHZ), CK), ns2cyc(lim_ns(G, L_CHZ), CK));
  localparam int C_WP  = ns2cyc(lim_ns(G, L_WP), CK);
  localparam int C_AW  = ns2cyc(lim_ns(G, L_AW), CK);
  localparam int C_DW  = ns2cyc(lim_ns(G, L_DW), CK);
  localparam int C_WR  = ns2cyc(lim_ns(G, L_WR), CK);
  localparam int N_RD    = imax(imax(C_AA, C_OE), C_RC);
  localparam int N_RTURN = C_HZ;
  localparam int N_PRE   = WR_BY_CS ? 1 : 0;
  localparam int N_HIZ   = ns2cyc(lim_ns(G, L_WHZ), CK);
  localparam int N_DAT   = imax(imax(C_DW, 1), imax(C_WP - N_HIZ, C_AW - N_HIZ));
  localparam int N_REC   = imax(C_WR, C_RC - N_PRE - N_HIZ - N_DAT);

  logic [1:0] rst_sync;
  logic       rst_sync_n;
  logic       accept;
  st_e        state_q, state_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  sram_ctl_seq #(
    .N_RD(N_RD), .N_RTURN(N_RTURN), .N_PRE(imax(N_PRE, 1)), .N_HIZ(N_HIZ),
    .N_DAT(N_DAT), .N_REC(imax(N_REC, 1)), .WR_BY_CS(WR_BY_CS)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_we(req_we),
    .accept(accept), .state_q(state_q), .state_d(state_d)
  );

  sram_ctl_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_BY_CS(WR_BY_CS)
  ) u_pins (
    .clk(clk), .rst_n(rst_sync_n), .state_q(state_q), .state_d(state_d),
    .accept(accept), .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_i(mem_dq_i),
    .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .addr(mem_addr),
    .dq_o(mem_dq_o), .dq_oe(mem_dq_oe), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign req_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe
);
  // R2
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && oe_n && we_n && !dq_oe));
  // R3
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R4
  read_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cs_n && we_n && !dq_oe));
  // R4
  write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R8
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!cs_n && !we_n));
  // R8
  release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (cs_n != we_n));
  // R6
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_o));
  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> $stable(addr));
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_valid(rd_valid), .cs_n(mem_cs_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
  .addr(mem_addr), .dq_o(mem_dq_o), .dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_env #(
  parameter bit WR_BY_CS = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_fail,
  output logic done
);
  // 20 ns grade limits in ns
  localparam real T_AA = 20.0, T_OE = 8.0, T_RC = 20.0, T_HZ = 8.0;
  localparam real T_WP = 15.0, T_AW = 15.0, T_DW = 10.0, T_WHZ = 10.0;

  logic        req_valid, req_ready, req_we, rd_valid;
  logic [16:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, rd_data, mem_dq_o, mem_dq_i;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;

  sram_ctl #(.CLK_PERIOD_NS(4), .SPEED_GRADE_NS(20), .WR_BY_CS(WR_BY_CS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // RAM model
  logic [7:0] ram [int];
  logic [7:0] shadow [int];
  logic [7:0] exp_q [$];
  logic       ram_drive;
  real t_addr = -1000.0, t_oe = -1000.0, t_rel = -1000.0, t_wef = -1000.0;
  real t_csf = -1000.0, t_dchg = -1000.0, t_drv = -1000.0;

  function automatic logic [7:0] ram_rd(input logic [16:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : 8'h00;
  endfunction

  assign ram_drive = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i  = mem_dq_oe ? mem_dq_o : (ram_drive ? ram_rd(mem_addr) : 8'h00);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (cs_mode=%0d) actual=%0d expected=%0d", req, WR_BY_CS, act, exp);
    end
  endtask

  always @(mem_addr) begin
    // R9: address changes at least a full cycle time apart
    chk(($realtime - t_addr) >= T_RC, "R9", int'($realtime - t_addr), int'(T_RC));
    t_addr = $realtime;
  end
  always @(negedge mem_oe_n) t_oe = $realtime;
  always @(posedge mem_oe_n) begin
    // R10: read cycle length
    chk(($realtime - t_oe) >= T_RC, "R10", int'($realtime - t_oe), int'(T_RC));
    t_rel = $realtime;
  end
  always @(posedge mem_cs_n) if (!mem_oe_n || t_rel == $realtime) t_rel = $realtime;
  always @(negedge mem_we_n) t_wef = $realtime;
  always @(negedge mem_cs_n) t_csf = $realtime;
  always @(mem_dq_o) t_dchg = $realtime;
  always @(posedge mem_dq_oe) begin
    t_drv = $realtime;
    // R8: wait out the write-to-high-Z window
    chk(($realtime - t_wef) >= T_WHZ, "R8", int'($realtime - t_wef), int'(T_WHZ));
  end

  task automatic wr_end(input bit by_cs);
    real start, dstart;
    start  = (t_wef > t_csf) ? t_wef : t_csf;
    dstart = (t_drv > t_dchg) ? t_drv : t_dchg;
    chk(by_cs == WR_BY_CS, "R7", by_cs, WR_BY_CS);
    chk(($realtime - start) >= T_WP, "R6", int'($realtime - start), int'(T_WP));
    chk(($realtime - t_addr) >= T_AW, "R6", int'($realtime - t_addr), int'(T_AW));
    chk(($realtime - dstart) >= T_DW && t_drv > start, "R6",
        int'($realtime - dstart), int'(T_DW));
    ram[int'(mem_addr)] = mem_dq_o;
  endtask

  always @(posedge mem_we_n) if (!mem_cs_n) wr_end(1'b0);
  always @(posedge mem_cs_n) if (!mem_we_n) wr_end(1'b1);

  // R8: no contention
  always @(negedge clk) if (rst_n && mem_dq_oe)
    chk(!ram_drive && ($realtime - t_rel) >= T_HZ, "R8", int'($realtime - t_rel), int'(T_HZ));

  always @(posedge rd_valid) begin
    // R5: access times met at the capture edge
    chk(($realtime - t_addr) >= T_AA, "R5", int'($realtime - t_addr), int'(T_AA));
    chk(($realtime - t_oe) >= T_OE, "R5", int'($realtime - t_oe), int'(T_OE));
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_q.size() == 0) chk(1'b0, "R5", rd_data, -1);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(rd_data == e, "R5", rd_data, e);
    end
  end

  task automatic issue(input bit we, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    if (we) shadow[int'(a)] = d;
    else    exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R3", req_ready, 0);
  endtask

  task automatic check_idle(input string req);
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rd_valid, req,
        {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rd_valid}, 6'b111010);
  endtask

  logic [16:0] addrs [16];

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    @(negedge clk);
    check_idle("R1");
    wait (rst_n);
    repeat (4) @(negedge clk);
    check_idle("R1");
    for (int i = 0; i < 16; i++) begin
      addrs[i] = (i == 0) ? 17'h00000 : (i == 1) ? 17'h1FFFF : 17'($urandom);
      issue(1'b1, addrs[i], 8'($urandom));
    end
    for (int i = 0; i < 16; i++) issue(1'b0, addrs[(i * 7 + 3) % 16], 8'h00);
    // write then immediately read same address (turnaround), read never-written
    issue(1'b1, 17'h0ABCD, 8'h5A);
    issue(1'b0, 17'h0ABCD, 8'h00);
    issue(1'b0, 17'h1FFFE, 8'h00);
    issue(1'b0, 17'h0ABCD, 8'h00);
    issue(1'b1, 17'h0ABCD, 8'hA5);
    issue(1'b0, 17'h0ABCD, 8'h00);
    @(negedge clk);
    while (!req_ready || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check_idle("R2");
    done = 1'b1;
  end
endmodule

module sram_ctl_tb;
  logic clk, rst_n;
  int   c0, f0, c1, f1;
  logic d0, d1;
  int   wd_fail;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  sram_ctl_env #(.WR_BY_CS(1'b0)) u_env_we (.clk(clk), .rst_n(rst_n), .n_chk(c0), .n_fail(f0), .done(d0));
  sram_ctl_env #(.WR_BY_CS(1'b1)) u_env_cs (.clk(clk), .rst_n(rst_n), .n_chk(c1), .n_fail(f1), .done(d1));

  initial begin
    wd_fail = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (d0 === 1'b1 && d1 === 1'b1) break;
      if (k == 19999) begin
        wd_fail = 1;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    end
    $display("[TB] %0d tests run, %0d failed", c0 + c1 + wd_fail, f0 + f1 + wd_fail);
    $finish;
  end
endmodule